// File: doc/BRIEF.md
# Dual-Slope Complementary PWM Timer

This block drives a pair of complementary waveforms from one 12-bit counter. The counter climbs from zero to a programmed peak and then descends back to zero, so one full period takes twice the peak value in counting steps. Channel A and channel B each switch on a compare value, and the direction of the count decides which way each one switches. Channel B is high around the peak of the triangle and channel A is high around its floor. When the B compare is above the A compare, the distance between the two values becomes a dead band on both sides. In that band neither output is high.

Software programs the block through a byte-wide write port. The peak and the two compares are each 12 bits, written as a low byte and then a high byte. A control register starts and stops the counter and gates each channel onto its output. A count-enable strobe sets the counting rate, standing in for a prescaler. The block produces a one-cycle pulse each time the counter arrives at the peak. A ready flag models the delay for the control setting to cross into the counter's clock domain.

Top module: `dspwm_timer`

## Requirements
- R1: While running, each counting step moves the counter by one, from 0 up to the peak value and back down to 0. The cycle after the step that lands on the peak, `peak_evt` is high for exactly one cycle. With the strobe held high, successive pulses are 2×peak cycles apart.
- R2: Channel A's internal state goes high on a downward step that lands on the A compare, and low on an upward step that lands on it.
- R3: Channel B's internal state goes high on an upward step that lands on the B compare, and low on a downward step that lands on it.
- R4: With 0 < A compare < B compare < peak, `wave_a` and `wave_b` are never high together.
- R5: The ready flag is high after reset. An accepted control write (address 6) drives it low for exactly 3 cycles, after which it is high again.
- R6: A control write made while the ready flag is low has no effect. It does not start the counter and does not extend the low time of the ready flag.
- R7: Control bit 0 is the run bit. Bit 1 gates channel A onto its output and bit 2 gates channel B. An accepted control write always updates bit 0. It updates bits 1 and 2 only if the counter was stopped before the write.
- R8: A channel whose gate bit is 0 drives its output at 0, while the other channel keeps switching.
- R9: Address pairs (0,1), (2,3) and (4,5) hold the peak, the A compare and the B compare, low byte first. A low-byte write alone changes nothing. The high-byte write, in bits 3:0, commits the combined 12-bit value.
- R10: While the counter is stopped, committed values take effect at once. While it is running, they take effect on the step that brings the counter to 0, so a period never mixes old and new values.
- R11: The counter moves only in cycles where `tick` is high. With `tick` high every second cycle, peak pulses are 4×peak cycles apart.
- R12: After reset, and one cycle after the counter is stopped, the count is 0, counting is upward, and both outputs and `peak_evt` are 0.
- R13: With a peak value of 0 the counter holds at 0: no peak pulses and no output switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..5 hold the compare bytes, 6 is control |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Count enable; one counting step per high cycle |
| wave_a | output | 1 | Channel A waveform, gated by its enable |
| wave_b | output | 1 | Channel B waveform, gated by its enable |
| ready | output | 1 | High when a control write will be accepted |
| peak_evt | output | 1 | One-cycle pulse when the counter reaches the peak |

## Verification
A cycle-exact model runs in parallel with the design. It is driven through a near-exhaustive sweep of small peak values and every ordered pair of A and B compares below them. This separates errors in the direction-dependent set and clear rules from errors in the turnaround at the peak and at zero. Peak-pulse spacing is measured under a continuous strobe, under an alternating strobe, under a peak above 255, under a low-byte-only write, and across a peak change made in mid-run. These five cases tell apart the byte assembly, the count-enable gating and the zero-crossing reload. Counting the high cycles of each output over whole periods, with one channel gated off and after a refused mid-run enable change, confirms the gate and the register lock.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
   localparam int ADDR_W    = 3;
   localparam int N_CMP     = 3;
   localparam int IDX_PEAK  = 0;
   localparam int IDX_ASET  = 1;
   localparam int IDX_BSET  = 2;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd6;
   localparam int BIT_RUN   = 0;
   localparam int BIT_OE_A  = 1;
   localparam int BIT_OE_B  = 2;
   localparam int N_CHAN    = 2;

   typedef struct packed {
      logic run;
      logic oe_a;
      logic oe_b;
   } ctrl_t;
endpackage

// File: rtl/dspwm_regs.sv
module dspwm_regs
   import dspwm_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int BUS_W     = 8,
   parameter int READY_LAT = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic                zero_load,
   output ctrl_t               ctrl,
   output logic                ready,
   output logic [CNT_W-1:0]    peak,
   output logic [CNT_W-1:0]    aset,
   output logic [CNT_W-1:0]    bset
);
   localparam int HI_W = CNT_W - BUS_W;
   localparam int BSY_W = $clog2(READY_LAT + 1);

   logic [BUS_W-1:0] lo_q   [N_CMP];
   logic [CNT_W-1:0] pend_q [N_CMP];
   logic [CNT_W-1:0] act_q  [N_CMP];
   logic [BSY_W-1:0] busy_q;
   ctrl_t            ctrl_q;
   logic             ctrl_acc;
   logic             unused_hi;

   assign unused_hi = ^wr_data[BUS_W-1:HI_W];
   assign ctrl_acc  = wr_en && (wr_addr == CTRL_ADDR) && (busy_q == '0);
   assign ready     = (busy_q == '0);
   assign ctrl      = ctrl_q;

   generate
      for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
         localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * i);
         localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * i + 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q[i]   <= '0;
               pend_q[i] <= '0;
               act_q[i]  <= '0;
            end else begin
               if (wr_en && wr_addr == A_LO)
                  lo_q[i] <= wr_data;
               if (wr_en && wr_addr == A_HI)
                  pend_q[i] <= {wr_data[HI_W-1:0], lo_q[i]};
               if (!ctrl_q.run || zero_load)
                  act_q[i] <= pend_q[i];
            end
         end
      end
   endgenerate

   assign peak = act_q[IDX_PEAK];
   assign aset = act_q[IDX_ASET];
   assign bset = act_q[IDX_BSET];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         ctrl_q <= '0;
      end else if (ctrl_acc) begin
         busy_q     <= BSY_W'(READY_LAT);
         ctrl_q.run <= wr_data[BIT_RUN];
         if (!ctrl_q.run) begin
            ctrl_q.oe_a <= wr_data[BIT_OE_A];
            ctrl_q.oe_b <= wr_data[BIT_OE_B];
         end
      end else if (busy_q != '0) begin
         busy_q <= busy_q - 1'b1;
      end
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_acc |=> !ready); // R5
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == CTRL_ADDR && !ready) |=> $stable(ctrl_q.run)); // R6
   AST_OE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.run |=> ($stable(ctrl_q.oe_a) && $stable(ctrl_q.oe_b))); // R7
endmodule

// File: rtl/dspwm_core.sv
module dspwm_core #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] peak,
   output logic [CNT_W-1:0] nxt,
   output logic             step_up,
   output logic             step_mv,
   output logic             zero_load,
   output logic             peak_evt
);
   logic [CNT_W-1:0] cnt_q;
   logic             up_q;
   logic             nxt_up;
   logic             step;
   logic             peak_q;

   assign step = run && tick;

   always_comb begin
      nxt    = cnt_q;
      nxt_up = up_q;
      if (peak == '0) begin
         nxt    = '0;
         nxt_up = 1'b1;
      end else if (up_q) begin
         if (cnt_q >= peak) begin
            nxt    = cnt_q - 1'b1;
            nxt_up = 1'b0;
         end else begin
            nxt = cnt_q + 1'b1;
         end
      end else begin
         if (cnt_q == '0) begin
            nxt    = CNT_W'(1);
            nxt_up = 1'b1;
         end else begin
            nxt = cnt_q - 1'b1;
         end
      end
   end

   assign step_up   = nxt_up;
   assign step_mv   = step && (nxt != cnt_q);
   assign zero_load = step && (nxt == '0);
   assign peak_evt  = peak_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         up_q   <= 1'b1;
         peak_q <= 1'b0;
      end else if (!run) begin
         cnt_q  <= '0;
         up_q   <= 1'b1;
         peak_q <= 1'b0;
      end else begin
         peak_q <= step_mv && nxt_up && (nxt == peak);
         if (step) begin
            cnt_q <= nxt;
            up_q  <= nxt_up;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= peak); // R1
   AST_PEAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      peak_q |=> !peak_q); // R1
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q)); // R11
   AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0 && up_q && !peak_q)); // R12
endmodule

// File: rtl/dspwm_chan.sv
module dspwm_chan #(
   parameter int CNT_W      = 12,
   parameter bit RISE_ON_UP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step_mv,
   input  logic             step_up,
   input  logic [CNT_W-1:0] nxt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             oe,
   output logic             wave
);
   logic state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= 1'b0;
      else if (!run)
         state_q <= 1'b0;
      else if (step_mv && nxt == cmp)
         state_q <= (step_up == RISE_ON_UP);
   end

   assign wave = state_q && oe;

   AST_CHAN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !wave); // R12
   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_mv |=> $stable(state_q) || !$past(run)); // R2
endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
   import dspwm_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int BUS_W     = 8,
   parameter int READY_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             tick,
   output logic             wave_a,
   output logic             wave_b,
   output logic             ready,
   output logic             peak_evt
);
   generate
      if (CNT_W <= BUS_W || CNT_W >= 2 * BUS_W) begin : g_bad_width
         $error("dspwm_timer: CNT_W must lie strictly between BUS_W and 2*BUS_W");
      end
      if (BUS_W != 8) begin : g_bad_bus
         $error("dspwm_timer: port width fixed at 8 bits");
      end
      if (READY_LAT < 1) begin : g_bad_lat
         $error("dspwm_timer: READY_LAT must be at least 1");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] peak, aset, bset, nxt;
   logic             step_up, step_mv, zero_load;
   logic [CNT_W-1:0] cmp_v  [N_CHAN];
   logic             oe_v   [N_CHAN];
   logic             wave_v [N_CHAN];

   dspwm_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .READY_LAT(READY_LAT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .zero_load(zero_load), .ctrl(ctrl), .ready(ready),
      .peak(peak), .aset(aset), .bset(bset)
   );

   dspwm_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick), .peak(peak),
      .nxt(nxt), .step_up(step_up), .step_mv(step_mv),
      .zero_load(zero_load), .peak_evt(peak_evt)
   );

   assign cmp_v[0] = aset;
   assign cmp_v[1] = bset;
   assign oe_v[0]  = ctrl.oe_a;
   assign oe_v[1]  = ctrl.oe_b;

   generate
      for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
         dspwm_chan #(.CNT_W(CNT_W), .RISE_ON_UP(c == 1)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(ctrl.run), .step_mv(step_mv),
            .step_up(step_up), .nxt(nxt), .cmp(cmp_v[c]), .oe(oe_v[c]),
            .wave(wave_v[c])
         );
      end
   endgenerate

   assign wave_a = wave_v[0];
   assign wave_b = wave_v[1];

   AST_GATE_A: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.oe_a |-> !wave_a); // R8
endmodule

// File: tb/dspwm_timer_bench.sv
`timescale 1ns/1ps
module dspwm_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tick = 1'b1;
   logic       wave_a, wave_b, ready, peak_evt;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  mdl_on = 1'b0;
   bit  excl_on = 1'b0;
   bit  tick_alt = 1'b0;

   always #2 clk = ~clk;

   dspwm_timer u_dspwm_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .wave_a(wave_a), .wave_b(wave_b),
      .ready(ready), .peak_evt(peak_evt)
   );

   // reference model built from the requirements
   logic [11:0] m_cnt, m_peak, m_as, m_bs;
   logic [11:0] m_pend [3];
   logic [7:0]  m_lo   [3];
   logic        m_up, m_a, m_b, m_pk, m_run, m_oea, m_oeb;
   int          m_busy;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_peak = 0; m_as = 0; m_bs = 0; m_up = 1;
         m_a = 0; m_b = 0; m_pk = 0; m_run = 0; m_oea = 0; m_oeb = 0; m_busy = 0;
         for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_lo[i] = 0; end
      end else begin
         logic [11:0] n; logic nu, mv, stp, acc, ld;
         acc = wr_en && wr_addr == 3'd6 && m_busy == 0;
         stp = m_run && tick;
         n = m_cnt; nu = m_up;
         if (m_peak == 0) begin n = 0; nu = 1; end
         else if (m_up) begin
            if (m_cnt >= m_peak) begin n = m_cnt - 1; nu = 0; end else n = m_cnt + 1;
         end else begin
            if (m_cnt == 0) begin n = 1; nu = 1; end else n = m_cnt - 1;
         end
         mv = stp && (n != m_cnt);
         ld = stp && (n == 0);
         if (!m_run) begin
            m_cnt = 0; m_up = 1; m_a = 0; m_b = 0; m_pk = 0;
         end else begin
            m_pk = mv && nu && (n == m_peak);
            if (mv && n == m_as) m_a = !nu;   // R2
            if (mv && n == m_bs) m_b = nu;    // R3
            if (stp) begin m_cnt = n; m_up = nu; end
         end
         if (!m_run || ld) begin
            m_peak = m_pend[0]; m_as = m_pend[1]; m_bs = m_pend[2];
         end
         for (int i = 0; i < 3; i++) begin
            if (wr_en && wr_addr == 3'(2*i)) m_lo[i] = wr_data;
            if (wr_en && wr_addr == 3'(2*i+1)) m_pend[i] = {wr_data[3:0], m_lo[i]};
         end
         if (acc) begin
            m_busy = 3;
            if (!m_run) begin m_oea = wr_data[1]; m_oeb = wr_data[2]; end
            m_run = wr_data[0];
         end else if (m_busy > 0) begin
            m_busy = m_busy - 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (mdl_on) begin
         check(wave_a == (m_a && m_oea), "R2 wave_a", wave_a, m_a && m_oea);
         check(wave_b == (m_b && m_oeb), "R3 wave_b", wave_b, m_b && m_oeb);
         check(ready == (m_busy == 0), "R5 ready", ready, m_busy == 0);
         check(peak_evt == m_pk, "R1 peak_evt", peak_evt, m_pk);
         if (excl_on) check(!(wave_a && wave_b), "R4 overlap", wave_a && wave_b, 0);
      end
      if (tick_alt) tick <= ~tick; else tick <= 1'b1;
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ctl(input logic [7:0] d);
      while (!ready) @(negedge clk);
      wr(3'd6, d);
   endtask

   task automatic set12(input int idx, input int v);
      wr(3'(2*idx), 8'(v & 8'hFF));
      wr(3'(2*idx+1), 8'((v >> 8) & 8'h0F));
   endtask

   task automatic cfg(input int pk, input int as, input int bs, input logic [7:0] c);
      ctl(8'h06);
      set12(0, pk); set12(1, as); set12(2, bs);
      ctl(c);
   endtask

   task automatic spacing(output int iv);
      int n = 0;
      while (!peak_evt && n < 5000) begin @(negedge clk); n++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!peak_evt && n < 5000);
      iv = n;
   endtask

   task automatic count_high(input int cyc, output int ca, output int cb, output int cp);
      ca = 0; cb = 0; cp = 0;
      repeat (cyc) begin
         @(negedge clk);
         ca += wave_a; cb += wave_b; cp += peak_evt;
      end
   endtask

   initial begin
      int iv, ca, cb, cp, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 / R5: reset state
      check(!wave_a && !wave_b && !peak_evt, "R12 reset outputs", {wave_a, wave_b, peak_evt}, 0);
      check(ready, "R5 ready after reset", ready, 1);
      mdl_on = 1'b1;

      // R5: ready low for exactly 3 cycles
      ctl(8'h06);
      check(!ready, "R5 low 1", ready, 0);
      @(negedge clk); check(!ready, "R5 low 2", ready, 0);
      @(negedge clk); check(!ready, "R5 low 3", ready, 0);
      @(negedge clk); check(ready, "R5 back high", ready, 1);

      // R6: control write during busy window ignored
      set12(0, 5); set12(1, 2); set12(2, 3);
      ctl(8'h06);
      wr(3'd6, 8'h07);
      n = 1;
      while (!ready) begin @(negedge clk); n++; end
      check(n == 3, "R6 busy not extended", n, 3);
      count_high(30, ca, cb, cp);
      check(cp == 0 && ca == 0 && cb == 0, "R6 not started", cp + ca + cb, 0);

      // R1/R2/R3/R4: near-exhaustive sweep of small configurations
      for (int pk = 4; pk <= 7; pk++)
         for (int as = 1; as <= pk - 2; as++)
            for (int bs = as + 1; bs <= pk - 1; bs++) begin
               excl_on = 1'b0;
               cfg(pk, as, bs, 8'h07);
               excl_on = 1'b1;
               repeat (4 * pk + 4) @(negedge clk);
            end
      excl_on = 1'b0;

      // R1: spacing with steady tick
      cfg(10, 4, 6, 8'h07);
      spacing(iv);
      check(iv == 20, "R1 peak spacing", iv, 20);

      // R7: enable change refused while running; run bit taken
      ctl(8'h01);
      count_high(40, ca, cb, cp);
      check(ca == 16, "R7 wave_a still gated on", ca, 16);
      check(cb == 16, "R7 wave_b still gated on", cb, 16);

      // R12: stop clears outputs
      ctl(8'h06);
      @(negedge clk);
      check(!wave_a && !wave_b && !peak_evt, "R12 stop clears", {wave_a, wave_b, peak_evt}, 0);

      // R8: channel A gated off
      cfg(10, 4, 6, 8'h05);
      count_high(40, ca, cb, cp);
      check(ca == 0, "R8 wave_a off", ca, 0);
      check(cb == 16, "R8 wave_b runs", cb, 16);
      check(cp == 2, "R1 two peaks per 40", cp, 2);

      // R9: low byte alone does nothing
      cfg(10, 4, 6, 8'h07);
      ctl(8'h06);
      wr(3'd0, 8'h07);
      ctl(8'h07);
      spacing(iv);
      check(iv == 20, "R9 low byte only", iv, 20);
      // R9: high byte commits a value above 255
      ctl(8'h06);
      wr(3'd0, 8'h04); wr(3'd1, 8'h01);
      ctl(8'h07);
      spacing(iv);
      check(iv == 520, "R9 12-bit peak", iv, 520);

      // R10: peak changed in mid-run takes effect at zero
      cfg(10, 3, 6, 8'h07);
      n = 0;
      while (!peak_evt && n < 5000) begin @(negedge clk); n++; end
      n = 0;
      wr(3'd0, 8'd16); n++;
      wr(3'd1, 8'd0);  n++;
      while (!peak_evt && n < 5000) begin @(negedge clk); n++; end
      check(n == 26, "R10 mixed period", n, 26);
      spacing(iv);
      check(iv == 32, "R10 new period", iv, 32);

      // R11: alternating tick
      cfg(10, 4, 6, 8'h07);
      tick_alt = 1'b1;
      spacing(iv);
      spacing(iv);
      check(iv == 40, "R11 half-rate spacing", iv, 40);
      tick_alt = 1'b0;

      // R13: peak of zero holds the counter
      cfg(0, 0, 0, 8'h07);
      count_high(40, ca, cb, cp);
      check(cp == 0 && ca == 0 && cb == 0, "R13 zero peak", cp + ca + cb, 0);

      mdl_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule